// File: doc/BRIEF.md
# Paging Receiver Interrupt Status Controller

This block gathers event strobes and level indicators from the units of a paging receiver. It keeps them in an 8-bit status word that clears on read, and it drives one external interrupt line. The controller reads the status word and writes a control register through a small indexed front end. An index register picks the target. A data read at the status index returns the word and counts as a status read operation.

Interrupt sources fall into two classes. The immediate class raises the line at once: pointer match, alert timeout, periodic timeout and any change of receiver enable. The deferred class only raises the line while the receiver is off: call data ready, an out-of-range change and a battery-low change. A deferred event that arrives while the receiver is on is held back. A held call-data event is released at the next sync-word strobe. Any held event is released when the receiver enable goes low.

The interrupt line is driven by a three-state machine:
- `IRQ_QUIET`: nothing is outstanding.
- `IRQ_HELD`: a deferred event waits and the line stays inactive.
- `IRQ_RAISED`: the line is active.

Transitions:
- QUIET→RAISED: an immediate event, or a deferred event with the receiver off.
- QUIET→HELD: a deferred event with the receiver on.
- HELD→RAISED: an immediate event, the receiver is off, or a sync strobe while a call is held.
- any→QUIET: a status read with no new qualifying event in that cycle.
- any→HELD or RAISED: a status read in the same cycle as a new event. The new event is judged as if the machine had started from QUIET.

Top module: `pgr_irq_ctrl`

## Requirements
- R1: After reset the event bits read 0, the interrupt is inactive (`irq_pin` equals the inverse of `irq_pol`), the index is 0 and `ctrl_o` is 0.
- R2: One cycle after a strobe, the matching status bit is 1: D0 user address, D2 call data, D3 pointer match, D4 alert timeout, D7 periodic timeout.
- R3: D1, D5 and D6 show the receiver-enable, out-of-range and battery-low levels one cycle late. A status read does not clear them.
- R4: A pointer match, an alert timeout, a periodic timeout or any change of receiver enable makes the interrupt active one cycle later.
- R5: A call-data strobe, an out-of-range change or a battery-low change makes the interrupt active one cycle later when receiver enable reads 0 (D1=0). When D1=1 the interrupt stays inactive.
- R6: A held call-data event makes the interrupt active one cycle after the next `sync_stb`. A sync strobe does not release a held out-of-range or battery-low event.
- R7: A held deferred event is released when receiver enable falls.
- R8: The user-address strobe (D0) never makes the interrupt active.
- R9: A status read sets the event bits to 0 and deactivates the interrupt one cycle later. It also discards any held event, so a later sync strobe raises nothing.
- R10: An event whose strobe arrives in the same cycle as a status read is set in the status word after the read, and it raises the interrupt if it qualifies.
- R11: The interrupt is active when `irq_pin` equals `irq_pol` (1 = active high, 0 = active low).
- R12: Only bits [3:0] of the written index are used. A read clears the status only when the index is 0, and `rdata` then returns the status word. A data write to any nonzero index, including 0BH–0FH, leaves `ctrl_o` unchanged.
- R13: A data write at index 0 stores `wdata` in the control register, which is shown on `ctrl_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ev_user_addr | input | 1 | strobe, reception started on an enabled user address |
| ev_call_rdy | input | 1 | strobe, call data available |
| ev_ptr_eq | input | 1 | strobe, SRAM read and write pointers equal |
| ev_alert | input | 1 | strobe, alert timeout expired |
| ev_periodic | input | 1 | strobe, periodic timeout expired |
| lv_oor | input | 1 | out-of-range level |
| lv_batlow | input | 1 | battery-low level |
| lv_rxen | input | 1 | receiver enable level |
| sync_stb | input | 1 | sync-word position strobe |
| irq_pol | input | 1 | interrupt active level |
| idx_we | input | 1 | write `wdata` into the index register |
| data_we | input | 1 | data write at the current index |
| data_re | input | 1 | data read at the current index |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data (status at index 0) |
| status_o | output | 8 | status word |
| ctrl_o | output | 8 | control register |
| irq_pin | output | 1 | interrupt output |

## Verification
A status read can fall in the same cycle as a new event strobe. The bench provokes this by raising a pointer-match strobe during the read cycle. It expects D3 to be set and the interrupt to be active after that edge, and then to clear on the following read. A receiver-enable fall can also coincide with a held deferred event. In that case the bench expects a single activation, with the live bits showing the new levels.

// File: rtl/pgr_irq_pkg.sv
package pgr_irq_pkg;
    localparam int STAT_W   = 8;
    localparam int IDX_W    = 4;
    localparam int N_LVL    = 3;
    localparam int B_ADDR   = 0;
    localparam int B_RXE    = 1;
    localparam int B_CALL   = 2;
    localparam int B_PTR    = 3;
    localparam int B_ALERT  = 4;
    localparam int B_OOR    = 5;
    localparam int B_BAT    = 6;
    localparam int B_PER    = 7;
    localparam int L_OOR    = 0;
    localparam int L_BAT    = 1;
    localparam int L_RXE    = 2;
    localparam logic [IDX_W-1:0] IDX_STATUS = '0;

    typedef enum logic [1:0] {
        IRQ_QUIET  = 2'd0,
        IRQ_HELD   = 2'd1,
        IRQ_RAISED = 2'd2
    } irq_state_e;
endpackage

// File: rtl/pgr_lvl_watch.sv
module pgr_lvl_watch
    import pgr_irq_pkg::*;
#(
    parameter int N = N_LVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_in,
    output logic [N-1:0] lvl_q,
    output logic [N-1:0] lvl_chg
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_lvl
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q[g] <= 1'b0;
                else        lvl_q[g] <= lvl_in[g];
            end
            assign lvl_chg[g] = lvl_in[g] ^ lvl_q[g];
        end
    endgenerate
endmodule

// File: rtl/pgr_stat_reg.sv
module pgr_stat_reg
    import pgr_irq_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev_set,
    input  logic [W-1:0] live,
    input  logic         clr,
    output logic [W-1:0] status
);
    localparam logic [W-1:0] LIVE_MASK = (W'(1) << B_RXE) | (W'(1) << B_OOR) | (W'(1) << B_BAT);
    localparam logic [W-1:0] EV_MASK   = ~LIVE_MASK;

    logic [W-1:0] ev_q;
    logic [W-1:0] ev_d;

    always_comb begin
        if (clr) ev_d = ev_set & EV_MASK;
        else     ev_d = (ev_q | ev_set) & EV_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign status = ev_q | (live & LIVE_MASK);

    p_ptr_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[B_PTR] |=> status[B_PTR]);
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ev_set == '0) |=> ((status & EV_MASK) == '0));
endmodule

// File: rtl/pgr_irq_fsm.sv
module pgr_irq_fsm
    import pgr_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic imm_ev,
    input  logic def_ev,
    input  logic call_ev,
    input  logic sync_stb,
    input  logic rx_on,
    input  logic clr,
    input  logic pol,
    output logic active,
    output logic irq_pin
);
    irq_state_e state, base, nxt;
    logic pend_call, pend_base, pend_nxt;

    always_comb begin
        base      = clr ? IRQ_QUIET : state;
        pend_base = clr ? 1'b0 : pend_call;
        nxt       = base;
        unique case (base)
            IRQ_QUIET: begin
                if (imm_ev || (def_ev && !rx_on)) nxt = IRQ_RAISED;
                else if (def_ev)                  nxt = IRQ_HELD;
            end
            IRQ_HELD: begin
                if (imm_ev || !rx_on || (sync_stb && pend_base)) nxt = IRQ_RAISED;
            end
            IRQ_RAISED: nxt = IRQ_RAISED;
            default:    nxt = IRQ_QUIET;
        endcase
        pend_nxt = (nxt == IRQ_HELD) ? (pend_base | call_ev) : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= IRQ_QUIET;
            pend_call <= 1'b0;
        end else begin
            state     <= nxt;
            pend_call <= pend_nxt;
        end
    end

    always_comb begin
        active  = (state == IRQ_RAISED);
        irq_pin = active ? pol : ~pol;
    end

    p_imm_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        imm_ev |=> active);
    p_read_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !imm_ev && !def_ev) |=> !active);
    p_held_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !imm_ev && !sync_stb && rx_on && !clr) |=> !active);
endmodule

// File: rtl/pgr_reg_front.sv
module pgr_reg_front
    import pgr_irq_pkg::*;
#(
    parameter int W  = STAT_W,
    parameter int IW = IDX_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idx_we,
    input  logic         data_we,
    input  logic         data_re,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] status,
    output logic [W-1:0] rdata,
    output logic [W-1:0] ctrl,
    output logic         stat_clr
);
    logic [IW-1:0] idx_q;
    logic          at_status;

    assign at_status = (idx_q == IDX_STATUS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            ctrl  <= '0;
        end else begin
            if (idx_we)                idx_q <= wdata[IW-1:0];
            if (data_we && at_status)  ctrl  <= wdata;
        end
    end

    always_comb begin
        rdata    = at_status ? status : '0;
        stat_clr = data_re && at_status;
    end

    p_ctrl_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !at_status) |=> $stable(ctrl));
endmodule

// File: rtl/pgr_irq_ctrl.sv
module pgr_irq_ctrl
    import pgr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_user_addr,
    input  logic              ev_call_rdy,
    input  logic              ev_ptr_eq,
    input  logic              ev_alert,
    input  logic              ev_periodic,
    input  logic              lv_oor,
    input  logic              lv_batlow,
    input  logic              lv_rxen,
    input  logic              sync_stb,
    input  logic              irq_pol,
    input  logic              idx_we,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] rdata,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] ctrl_o,
    output logic              irq_pin
);
    logic [N_LVL-1:0]  lvl_q, lvl_chg;
    logic [STAT_W-1:0] ev_set, live;
    logic              stat_clr, imm_ev, def_ev, active;

    pgr_lvl_watch #(.N(N_LVL)) u_lvl (
        .clk(clk), .rst_n(rst_n),
        .lvl_in({lv_rxen, lv_batlow, lv_oor}),
        .lvl_q(lvl_q), .lvl_chg(lvl_chg)
    );

    always_comb begin
        ev_set          = '0;
        ev_set[B_ADDR]  = ev_user_addr;
        ev_set[B_CALL]  = ev_call_rdy;
        ev_set[B_PTR]   = ev_ptr_eq;
        ev_set[B_ALERT] = ev_alert;
        ev_set[B_PER]   = ev_periodic;
        live            = '0;
        live[B_RXE]     = lvl_q[L_RXE];
        live[B_OOR]     = lvl_q[L_OOR];
        live[B_BAT]     = lvl_q[L_BAT];
        imm_ev = ev_ptr_eq | ev_alert | ev_periodic | lvl_chg[L_RXE];
        def_ev = ev_call_rdy | lvl_chg[L_OOR] | lvl_chg[L_BAT];
    end

    pgr_stat_reg #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .live(live),
        .clr(stat_clr), .status(status_o)
    );

    pgr_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .imm_ev(imm_ev), .def_ev(def_ev),
        .call_ev(ev_call_rdy), .sync_stb(sync_stb), .rx_on(lvl_q[L_RXE]),
        .clr(stat_clr), .pol(irq_pol), .active(active), .irq_pin(irq_pin)
    );

    pgr_reg_front #(.W(STAT_W), .IW(IDX_W)) u_front (
        .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .data_we(data_we),
        .data_re(data_re), .wdata(wdata), .status(status_o),
        .rdata(rdata), .ctrl(ctrl_o), .stat_clr(stat_clr)
    );

    p_addr_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && ev_user_addr && !imm_ev && !def_ev && !sync_stb) |=> !active);
    p_live_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (status_o[B_OOR] == $past(lv_oor) && status_o[B_BAT] == $past(lv_batlow)));
    p_pin_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (irq_pin == irq_pol));
endmodule

// File: tb/pgr_irq_ctrl_tb.sv
module pgr_irq_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_addr = 0, s_call = 0, s_ptr = 0, s_alert = 0, s_per = 0, s_sync = 0;
    logic oor = 0, bat = 0, rxe = 0, pol = 1'b1;
    logic iwe = 0, dwe = 0, dre = 0;
    logic [7:0] wd = '0;
    logic [7:0] rdata, status_o, ctrl_o;
    logic irq_pin;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        string      req;
        logic [7:0] st;
        logic       act;
        logic [7:0] ct;
    } item_t;
    item_t q[$];
    logic [7:0] exp_ctrl = '0;

    always #4 clk = ~clk;

    pgr_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ev_user_addr(s_addr), .ev_call_rdy(s_call),
        .ev_ptr_eq(s_ptr), .ev_alert(s_alert), .ev_periodic(s_per),
        .lv_oor(oor), .lv_batlow(bat), .lv_rxen(rxe), .sync_stb(s_sync),
        .irq_pol(pol), .idx_we(iwe), .data_we(dwe), .data_re(dre), .wdata(wd),
        .rdata(rdata), .status_o(status_o), .ctrl_o(ctrl_o), .irq_pin(irq_pin)
    );

    function automatic logic [7:0] live();
        return {1'b0, bat, oor, 3'b000, rxe, 1'b0};
    endfunction

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: applies the strobes set by the caller for one edge and queues the expectation
    task automatic step(string req, logic [7:0] ev_bits, logic act);
        item_t it;
        it.req = req; it.st = ev_bits | live(); it.act = act; it.ct = exp_ctrl;
        q.push_back(it);
        @(posedge clk);
        @(negedge clk);
        {s_addr, s_call, s_ptr, s_alert, s_per, s_sync, iwe, dwe, dre} = '0;
    endtask

    // monitor: compares away from the active edge
    always @(posedge clk) begin
        #2;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check(it.req, "status", status_o, it.st);
            check(it.req, "irq_pin", {7'd0, irq_pin}, {7'd0, it.act ? pol : ~pol});
            check(it.req, "ctrl", ctrl_o, it.ct);
        end
    end

    task automatic do_read(string req, logic [7:0] ev_after, logic act_after, logic [7:0] exp_rd);
        dre = 1'b1;
        #1;
        check(req, "rdata", rdata, exp_rd);
        step(req, ev_after, act_after);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "status in reset", status_o, 8'h00);
        check("R1", "irq in reset", {7'd0, irq_pin}, 8'h00);
        rst_n = 1'b1;
        step("R1", 8'h00, 0);

        s_ptr = 1;   step("R4 R2 ptr", 8'h08, 1);
        do_read("R9 read", 8'h00, 0, 8'h08);
        s_alert = 1; step("R4 R2 alert", 8'h10, 1);
        do_read("R9", 8'h00, 0, 8'h10);
        s_per = 1;   step("R4 R2 periodic", 8'h80, 1);
        do_read("R9", 8'h00, 0, 8'h80);
        s_addr = 1;  step("R8 R2 user addr", 8'h01, 0);
        do_read("R9", 8'h00, 0, 8'h01);

        rxe = 1;     step("R4 rxe rise", 8'h00, 1);
        do_read("R3 rxe kept", 8'h00, 0, 8'h02);
        s_call = 1;  step("R5 call held", 8'h04, 0);
        step("R5 still held", 8'h04, 0);
        s_sync = 1;  step("R6 sync release", 8'h04, 1);
        do_read("R9", 8'h00, 0, 8'h06);

        bat = 1;     step("R5 bat held", 8'h00, 0);
        s_sync = 1;  step("R6 sync no bat release", 8'h00, 0);
        rxe = 0;     step("R7 rxe fall", 8'h00, 1);
        do_read("R3 bat kept", 8'h00, 0, 8'h40);
        s_call = 1;  step("R5 call rx off", 8'h04, 1);
        do_read("R9", 8'h00, 0, 8'h44);
        oor = 1;     step("R5 oor rx off", 8'h00, 1);
        do_read("R3 oor kept", 8'h00, 0, 8'h60);

        s_ptr = 1;   do_read("R10 same cycle", 8'h08, 1, 8'h60);
        do_read("R10 then clear", 8'h00, 0, 8'h68);

        wd = 8'h35; iwe = 1; step("R12 idx 5", 8'h00, 0);
        s_ptr = 1;  step("R12 ptr", 8'h08, 1);
        do_read("R12 read idx5 no clear", 8'h08, 1, 8'h00);
        wd = 8'hAA; dwe = 1; step("R12 write idx5 ignored", 8'h08, 1);
        wd = 8'h0C; iwe = 1; step("R12 idx C", 8'h08, 1);
        wd = 8'h55; dwe = 1; step("R12 write idx C ignored", 8'h08, 1);
        wd = 8'hF0; iwe = 1; step("R12 idx F0 -> 0", 8'h08, 1);
        do_read("R12 read idx0 clears", 8'h00, 0, 8'h68);
        wd = 8'h5A; dwe = 1; exp_ctrl = 8'h5A; step("R13 ctrl write", 8'h00, 0);

        pol = 0;     step("R11 low inactive", 8'h00, 0);
        s_alert = 1; step("R11 low active", 8'h10, 1);
        do_read("R11 clear", 8'h00, 0, 8'h70);

        rxe = 1;     step("R4 rxe rise", 8'h00, 1);
        do_read("R9", 8'h00, 0, 8'h62);
        s_call = 1;  step("R5 held again", 8'h04, 0);
        do_read("R9 drops held", 8'h00, 0, 8'h66);
        s_sync = 1;  step("R9 sync after clear", 8'h00, 0);

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule